// File: doc/BRIEF.md
# Command-Response Buffer Control Register Block

This block is the host-facing control and status register file of a security co-processor that exchanges commands and responses through a shared memory buffer. A host bus issues register reads and writes of one to four bytes. The block tracks which locality owns the interface. It runs the ready/idle power handshake and the start/cancel command handshake. It also presents fixed identification, capability, buffer-size and buffer-address words.

Toward the command engine behind it, the block emits a one-cycle request pulse. The pulse carries the command length, which is the smaller of the length in the command header and the usable buffer size. The block also emits a one-cycle cancel pulse. It takes a one-cycle completion strobe with an error flag. The address bits above bit 11 select the locality of a write, so each locality sees the same register set in its own 4 KiB window.

Top module: `cmdbuf_ctrl_regs`

## Requirements
- R1: After reset the locality state word (offset 0x000) reads 0x80 with the established input high. The control status word (0x044) reads 0x2: bit1 is idle and bit0 is fatal. The command and response size words (0x058, 0x064) read CMD_SIZE = WIN_SIZE - BUF_OFFSET. The command and response address words (0x05C, 0x068) read BUF_BASE + BUF_OFFSET.
- R2: The interface identity word (0x030) reads 0x00025811, which gives type 1, version 1, transfer-size code 3, buffer capability 1 and selector 1. The second identity word (0x034) reads VENDOR_ID in bits 15:0.
- R3: A read returns the aligned word shifted right by 8 times address bits 1:0. Only size+1 low bytes are kept, where bus_size 0..3 means 1..4 bytes.
- R4: Reading the locality state word returns bit0 as the inverse of the est_flag input.
- R5: A write of exactly 1 to the control request word (0x040) clears idle. A write of exactly 2 sets idle. Any other value leaves idle unchanged.
- R6: A write of 1 to the locality control word (0x008) sets granted (bit0 of 0x00C), clears been-seized (bit1 of 0x00C), and sets assigned (bit1 of 0x000), with the writer's locality in bits 4:2 of 0x000. A write of 2 clears assigned, granted and the locality field. Any other value, 8 included, changes nothing.
- R7: A write of exactly 1 to the start word (0x04C) is accepted only when the start bit (bit0 of 0x04C) is clear and a locality is assigned that equals the writer's locality. Acceptance sets the start bit and gives exactly one be_req pulse in the next cycle.
- R8: be_req_len equals min(cmd_hdr_len, min(BE_BUF_SIZE, CMD_SIZE)), captured when the request is accepted.
- R9: A write of exactly 1 to the cancel word (0x048) gives one be_cancel pulse only while the start bit is set. Otherwise it has no effect.
- R10: be_done while the start bit is set clears the start bit. If be_done_err is also high, the fatal bit is set and stays set until reset. be_done while the start bit is clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits above 11 give the locality |
| bus_size | input | 2 | Access size minus one, in bytes |
| bus_wdata | input | 32 | Write data, little-endian low lanes |
| bus_rdata | output | 32 | Read data, aligned and masked |
| est_flag | input | 1 | Established flag from the engine |
| cmd_hdr_len | input | LEN_W | Length field from the command header |
| be_req | output | 1 | One-cycle command request pulse |
| be_req_len | output | LEN_W | Command length for the request |
| be_cancel | output | 1 | One-cycle cancel pulse |
| be_done | input | 1 | One-cycle completion strobe |
| be_done_err | input | 1 | Completion carried an error |

## Verification
The assertions assume three things about the inputs. be_done is a single-cycle strobe. be_done_err means something only alongside be_done. The engine never signals completion for a request it was not given. The bench raises be_done for exactly one cycle and only with err set as intended. The one exception is a deliberate stray completion while the start bit is clear, which the design must ignore. Bus accesses are held for one cycle and never overlap a completion strobe, so each register effect can be tied to a single edge.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

   // register offsets within one locality window; the host decodes these
   localparam logic [11:0] OFF_LOC_STATE = 12'h000;
   localparam logic [11:0] OFF_LOC_CTRL  = 12'h008;
   localparam logic [11:0] OFF_LOC_STS   = 12'h00C;
   localparam logic [11:0] OFF_INTF_ID   = 12'h030;
   localparam logic [11:0] OFF_INTF_ID2  = 12'h034;
   localparam logic [11:0] OFF_CTRL_REQ  = 12'h040;
   localparam logic [11:0] OFF_CTRL_STS  = 12'h044;
   localparam logic [11:0] OFF_CANCEL    = 12'h048;
   localparam logic [11:0] OFF_START     = 12'h04C;
   localparam logic [11:0] OFF_CMD_SIZE  = 12'h058;
   localparam logic [11:0] OFF_CMD_ADDR  = 12'h05C;
   localparam logic [11:0] OFF_RSP_SIZE  = 12'h064;
   localparam logic [11:0] OFF_RSP_ADDR  = 12'h068;

   // write codes
   localparam logic [31:0] LOCC_TAKE    = 32'd1;
   localparam logic [31:0] LOCC_GIVE    = 32'd2;
   localparam logic [31:0] PWR_READY    = 32'd1;
   localparam logic [31:0] PWR_IDLE     = 32'd2;
   localparam logic [31:0] INVOKE       = 32'd1;

   // identity word assembled from its fields
   function automatic logic [31:0] intf_word();
      logic [31:0] w;
      w          = '0;
      w[3:0]     = 4'd1;   // interface type: buffer, active
      w[7:4]     = 4'd1;   // interface version
      w[8]       = 1'b0;   // locality 0 only
      w[9]       = 1'b0;   // fast idle bypass
      w[12:11]   = 2'b11;  // 64-byte transfers
      w[13]      = 1'b0;   // no FIFO path
      w[14]      = 1'b1;   // buffer path supported
      w[18:17]   = 2'd1;   // selector: buffer interface
      w[31:24]   = 8'd0;   // revision
      return w;
   endfunction

endpackage

// File: rtl/cbr_lane_align.sv
module cbr_lane_align (
   input  logic [31:0] word,
   input  logic [1:0]  ofs,
   input  logic [1:0]  size,
   output logic [31:0] data
);
   logic [31:0] shifted;
   logic [31:0] mask;

   assign shifted = word >> {ofs, 3'b000};

   for (genvar b = 0; b < 4; b++) begin : g_lane
      assign mask[8*b +: 8] = (2'(b) <= size) ? 8'hFF : 8'h00;
   end

   assign data = shifted & mask;
endmodule

// File: rtl/cbr_loc_ctrl.sv
module cbr_loc_ctrl #(
   parameter int LOC_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [31:0]      wval,
   input  logic [LOC_W-1:0] req_loc,
   output logic             assigned,
   output logic [LOC_W-1:0] active_loc,
   output logic             granted,
   output logic             seized
);
   import cbr_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         assigned   <= 1'b0;
         active_loc <= '0;
         granted    <= 1'b0;
         seized     <= 1'b0;
      end else if (wr_en) begin
         if (wval == LOCC_TAKE) begin
            granted    <= 1'b1;
            seized     <= 1'b0;
            assigned   <= 1'b1;
            active_loc <= req_loc;
         end else if (wval == LOCC_GIVE) begin
            assigned   <= 1'b0;
            granted    <= 1'b0;
            active_loc <= '0;
         end
      end
   end
endmodule

// File: rtl/cbr_cmd_ctrl.sv
module cbr_cmd_ctrl #(
   parameter int LOC_W   = 3,
   parameter int LEN_W   = 16,
   parameter int BUF_LIM = 2048
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_wr,
   input  logic             cancel_wr,
   input  logic             start_wr,
   input  logic [31:0]      wval,
   input  logic [LOC_W-1:0] req_loc,
   input  logic             assigned,
   input  logic [LOC_W-1:0] active_loc,
   input  logic [LEN_W-1:0] cmd_hdr_len,
   input  logic             be_done,
   input  logic             be_done_err,
   output logic             idle,
   output logic             fatal,
   output logic             start,
   output logic             be_req,
   output logic [LEN_W-1:0] be_req_len,
   output logic             be_cancel
);
   import cbr_pkg::*;

   localparam logic [LEN_W-1:0] LIM = LEN_W'(BUF_LIM);

   logic             accept;
   logic [LEN_W-1:0] len_pick;

   assign accept   = start_wr && (wval == INVOKE) && !start &&
                     assigned && (active_loc == req_loc);
   assign len_pick = (cmd_hdr_len < LIM) ? cmd_hdr_len : LIM;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle       <= 1'b1;
         fatal      <= 1'b0;
         start      <= 1'b0;
         be_req     <= 1'b0;
         be_req_len <= '0;
         be_cancel  <= 1'b0;
      end else begin
         be_req    <= 1'b0;
         be_cancel <= 1'b0;
         if (pwr_wr) begin
            if (wval == PWR_READY)     idle <= 1'b0;
            else if (wval == PWR_IDLE) idle <= 1'b1;
         end
         if (cancel_wr && (wval == INVOKE) && start)
            be_cancel <= 1'b1;
         if (accept) begin
            start      <= 1'b1;
            be_req     <= 1'b1;
            be_req_len <= len_pick;
         end else if (be_done && start) begin
            start <= 1'b0;
            if (be_done_err) fatal <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/cmdbuf_ctrl_regs.sv
module cmdbuf_ctrl_regs #(
   parameter int          ADDR_W      = 15,
   parameter int          LEN_W       = 16,
   parameter int          BE_BUF_SIZE = 2048,
   parameter int          WIN_SIZE    = 4096,
   parameter int          BUF_OFFSET  = 128,
   parameter logic [31:0] BUF_BASE    = 32'hFED4_0000,
   parameter logic [15:0] VENDOR_ID   = 16'h5A5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              est_flag,
   input  logic [LEN_W-1:0]  cmd_hdr_len,
   output logic              be_req,
   output logic [LEN_W-1:0]  be_req_len,
   output logic              be_cancel,
   input  logic              be_done,
   input  logic              be_done_err
);
   import cbr_pkg::*;

   localparam int          LOC_W    = ADDR_W - 12;
   localparam int          CMD_SIZE = WIN_SIZE - BUF_OFFSET;
   localparam int          BUF_LIM  = (BE_BUF_SIZE < CMD_SIZE) ? BE_BUF_SIZE : CMD_SIZE;
   localparam logic [31:0] BUF_ADDR = BUF_BASE + 32'(BUF_OFFSET);
   localparam logic [31:0] ID_WORD  = intf_word();

   initial begin
      assert (LOC_W >= 1 && LOC_W <= 4) else $fatal(1, "ADDR_W must be 13..16");
      assert (BUF_OFFSET > 0 && BUF_OFFSET < WIN_SIZE) else $fatal(1, "bad buffer offset");
      assert (BUF_LIM < (1 << LEN_W)) else $fatal(1, "LEN_W too narrow");
   end

   logic [11:0]      reg_ofs;
   logic [11:0]      word_ofs;
   logic [LOC_W-1:0] req_loc;
   logic             wr_hit;
   logic [31:0]      wval;
   logic [31:0]      rd_word;

   logic             loc_assigned;
   logic [LOC_W-1:0] active_loc;
   logic             granted;
   logic             seized;
   logic             idle_bit;
   logic             fatal_bit;
   logic             start_bit;

   assign reg_ofs  = bus_addr[11:0];
   assign word_ofs = {reg_ofs[11:2], 2'b00};
   assign req_loc  = bus_addr[ADDR_W-1:12];
   assign wr_hit   = bus_sel && bus_wr && (reg_ofs[1:0] == 2'b00);

   cbr_lane_align i_wmask (
      .word (bus_wdata),
      .ofs  (2'b00),
      .size (bus_size),
      .data (wval)
   );

   cbr_loc_ctrl #(.LOC_W(LOC_W)) i_loc (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_hit && reg_ofs == OFF_LOC_CTRL),
      .wval       (wval),
      .req_loc    (req_loc),
      .assigned   (loc_assigned),
      .active_loc (active_loc),
      .granted    (granted),
      .seized     (seized)
   );

   cbr_cmd_ctrl #(.LOC_W(LOC_W), .LEN_W(LEN_W), .BUF_LIM(BUF_LIM)) i_cmd (
      .clk         (clk),
      .rst_n       (rst_n),
      .pwr_wr      (wr_hit && reg_ofs == OFF_CTRL_REQ),
      .cancel_wr   (wr_hit && reg_ofs == OFF_CANCEL),
      .start_wr    (wr_hit && reg_ofs == OFF_START),
      .wval        (wval),
      .req_loc     (req_loc),
      .assigned    (loc_assigned),
      .active_loc  (active_loc),
      .cmd_hdr_len (cmd_hdr_len),
      .be_done     (be_done),
      .be_done_err (be_done_err),
      .idle        (idle_bit),
      .fatal       (fatal_bit),
      .start       (start_bit),
      .be_req      (be_req),
      .be_req_len  (be_req_len),
      .be_cancel   (be_cancel)
   );

   always_comb begin
      rd_word = '0;
      case (word_ofs)
         OFF_LOC_STATE: begin
            rd_word[0]           = ~est_flag;
            rd_word[1]           = loc_assigned;
            rd_word[2 +: LOC_W]  = active_loc;
            rd_word[7]           = 1'b1;
         end
         OFF_LOC_STS:   rd_word[1:0]  = {seized, granted};
         OFF_INTF_ID:   rd_word       = ID_WORD;
         OFF_INTF_ID2:  rd_word[15:0] = VENDOR_ID;
         OFF_CTRL_STS:  rd_word[1:0]  = {idle_bit, fatal_bit};
         OFF_START:     rd_word[0]    = start_bit;
         OFF_CMD_SIZE,
         OFF_RSP_SIZE:  rd_word       = 32'(CMD_SIZE);
         OFF_CMD_ADDR,
         OFF_RSP_ADDR:  rd_word       = BUF_ADDR;
         default:       rd_word       = '0;
      endcase
   end

   cbr_lane_align i_ralign (
      .word (rd_word),
      .ofs  (reg_ofs[1:0]),
      .size (bus_size),
      .data (bus_rdata)
   );
endmodule

// File: rtl/cbr_checker.sv
module cbr_checker #(
   parameter int LEN_W   = 16,
   parameter int BUF_LIM = 2048
) (
   input logic             clk,
   input logic             rst_n,
   input logic             be_req,
   input logic [LEN_W-1:0] be_req_len,
   input logic             be_cancel,
   input logic             be_done,
   input logic             be_done_err,
   input logic             start_bit,
   input logic             fatal_bit,
   input logic             loc_assigned
);
   AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      be_req |=> !be_req); // R7
   AST_REQ_SETS_START: assert property (@(posedge clk) disable iff (!rst_n)
      be_req |-> start_bit); // R7
   AST_REQ_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
      be_req |-> loc_assigned); // R7
   AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      be_req |-> (be_req_len <= LEN_W'(BUF_LIM))); // R8
   AST_CANCEL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      be_cancel |-> $past(start_bit)); // R9
   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (be_done && start_bit) |=> !start_bit); // R10
   AST_ERR_FATAL: assert property (@(posedge clk) disable iff (!rst_n)
      (be_done && be_done_err && start_bit) |=> fatal_bit); // R10
   AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      fatal_bit |=> fatal_bit); // R10
endmodule

bind cmdbuf_ctrl_regs cbr_checker #(.LEN_W(LEN_W), .BUF_LIM(BUF_LIM)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .be_req       (be_req),
   .be_req_len   (be_req_len),
   .be_cancel    (be_cancel),
   .be_done      (be_done),
   .be_done_err  (be_done_err),
   .start_bit    (start_bit),
   .fatal_bit    (fatal_bit),
   .loc_assigned (loc_assigned)
);

// File: tb/test_cmdbuf_ctrl_regs.sv
module test_cmdbuf_ctrl_regs;
   localparam int CLK_PER = 10;
   localparam int ADDR_W  = 15;
   localparam int LEN_W   = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_sel = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [1:0]        bus_size = 2'd3;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              est_flag = 1'b1;
   logic [LEN_W-1:0]  cmd_hdr_len = '0;
   logic              be_req;
   logic [LEN_W-1:0]  be_req_len;
   logic              be_cancel;
   logic              be_done = 1'b0;
   logic              be_done_err = 1'b0;

   int errors = 0;
   int checks = 0;
   bit done_flag = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_PER/2) clk = ~clk;

   cmdbuf_ctrl_regs i_cmdbuf_ctrl_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .est_flag(est_flag), .cmd_hdr_len(cmd_hdr_len),
      .be_req(be_req), .be_req_len(be_req_len), .be_cancel(be_cancel),
      .be_done(be_done), .be_done_err(be_done_err)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: reads push the expected word into the scoreboard
   task automatic rd(logic [ADDR_W-1:0] a, logic [1:0] sz, logic [31:0] exp, string tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = sz;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_size = 2'd3; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic complete(logic err);
      @(negedge clk);
      be_done = 1'b1; be_done_err = err;
      @(negedge clk);
      be_done = 1'b0; be_done_err = 1'b0;
   endtask

   // monitor: compares read data a quarter period after the edge
   always begin
      @(posedge clk);
      #(CLK_PER/4);
      if (bus_sel && !bus_wr && exp_q.size() > 0) begin
         logic [31:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(t, bus_rdata, e);
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done_flag) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      rd(15'h000, 2'd3, 32'h80, "R1 loc state reset");
      rd(15'h044, 2'd3, 32'h2, "R1 ctrl sts reset");
      rd(15'h058, 2'd3, 32'hF80, "R1 cmd size");
      rd(15'h064, 2'd3, 32'hF80, "R1 rsp size");
      rd(15'h05C, 2'd3, 32'hFED40080, "R1 cmd addr");
      rd(15'h068, 2'd3, 32'hFED40080, "R1 rsp addr");
      rd(15'h030, 2'd3, 32'h00025811, "R2 intf id");
      rd(15'h034, 2'd3, 32'h00005A5A, "R2 intf id2");
      rd(15'h031, 2'd0, 32'h58, "R3 byte read");
      rd(15'h032, 2'd1, 32'h0002, "R3 half read upper");
      rd(15'h030, 2'd1, 32'h5811, "R3 half read lower");
      est_flag = 1'b0;
      rd(15'h000, 2'd3, 32'h81, "R4 established low");
      rd(15'h001, 2'd0, 32'h00, "R3 r4_ shifted byte");
      est_flag = 1'b1;

      complete(1'b1);
      rd(15'h044, 2'd3, 32'h2, "R10 stray done ignored");

      wr(15'h040, 32'd1);
      rd(15'h044, 2'd3, 32'h0, "R5 ready clears idle");
      wr(15'h040, 32'd3);
      rd(15'h044, 2'd3, 32'h0, "R5 other code ignored");
      wr(15'h040, 32'd2);
      rd(15'h044, 2'd3, 32'h2, "R5 go idle");
      wr(15'h040, 32'd1);

      wr(15'h04C, 32'd1);
      check("R7 start without locality", {31'b0, be_req}, 32'd0);
      rd(15'h04C, 2'd3, 32'h0, "R7 start bit clear");

      wr(15'h2008, 32'd1);
      rd(15'h000, 2'd3, 32'h8A, "R6 locality 2 assigned");
      rd(15'h00C, 2'd3, 32'h1, "R6 granted");

      wr(15'h004C, 32'd1);
      check("R7 wrong locality", {31'b0, be_req}, 32'd0);
      wr(15'h204C, 32'd3);
      check("R7 wrong value", {31'b0, be_req}, 32'd0);
      wr(15'h0048, 32'd1);
      check("R9 cancel while idle", {31'b0, be_cancel}, 32'd0);

      cmd_hdr_len = 16'h0020;
      wr(15'h204C, 32'd1);
      check("R7 request pulse", {31'b0, be_req}, 32'd1);
      check("R8 header length", {16'b0, be_req_len}, 32'h20);
      @(negedge clk);
      check("R7 pulse is one cycle", {31'b0, be_req}, 32'd0);
      rd(15'h204C, 2'd3, 32'h1, "R7 start bit set");
      wr(15'h204C, 32'd1);
      check("R7 no restart while busy", {31'b0, be_req}, 32'd0);
      wr(15'h2048, 32'd1);
      check("R9 cancel while busy", {31'b0, be_cancel}, 32'd1);

      complete(1'b0);
      rd(15'h204C, 2'd3, 32'h0, "R10 done clears start");
      rd(15'h0044, 2'd3, 32'h0, "R10 clean done no fatal");

      cmd_hdr_len = 16'hFFFF;
      wr(15'h204C, 32'd1);
      check("R8 length capped", {16'b0, be_req_len}, 32'h800);
      complete(1'b1);
      rd(15'h0044, 2'd3, 32'h1, "R10 error sets fatal");
      rd(15'h004C, 2'd3, 32'h0, "R10 error done clears start");
      wr(15'h2048, 32'd1);
      check("R9 cancel after done", {31'b0, be_cancel}, 32'd0);

      wr(15'h2008, 32'd8);
      rd(15'h00C, 2'd3, 32'h1, "R6 establishment reset no effect");
      rd(15'h000, 2'd3, 32'h8A, "R6 state kept");
      wr(15'h2008, 32'd2);
      rd(15'h000, 2'd3, 32'h80, "R6 relinquish");
      rd(15'h00C, 2'd3, 32'h0, "R6 granted cleared");
      wr(15'h204C, 32'd1);
      check("R7 start after relinquish", {31'b0, be_req}, 32'd0);
      wr(15'h040, 32'd2);
      rd(15'h044, 2'd3, 32'h3, "R10 fatal sticky");

      repeat (3) @(negedge clk);
      check("scoreboard drained", exp_q.size(), 32'd0);
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule